// File: doc/BRIEF.md
# Power-On Strap Latch and Clock Mode Controller

This block sits beside the PLLs and output dividers of a multi-output system clock generator. It samples two frequency-select straps and one USB/IO rate strap from dual-purpose pads once, on the first clock edge after reset is released. After that edge it turns those pads into outputs. A 3-bit clock mode ({test bit, select 1, select 0}) is decoded into divider select codes for the CPU, SDRAM, PCI, AGP and USB/IO clock paths. The decoder also raises an all-outputs-off flag and a test-mode flag.

The mode normally comes from the test pin and the two latched straps. When a register select input is high, a register-supplied 3-bit mode is used in their place. A concealed entry path also exists. Three rising edges on the PCI stop pin while the crystal input is held low force the block into test mode until the next reset. This happens whatever the selected mode source.

Top module: `strap_mode_ctrl`

## Requirements
- R1: `strap_oe_o` is 0 while `rst_ni` is low and during the cycle after reset release. It becomes 1 after the first rising clock edge with reset high and stays 1 until the next reset.
- R2: `fs_pad_i` and `usb_pad_i` are captured on that first edge only. Later changes on those pads have no effect on any output.
- R3: Mode 000 drives `hiz_o`=1 and every select code to 0.
- R4: CPU code by mode: 001→1 (50 MHz), 010→2 (66 MHz), 100→3 (90 MHz), 111→4 (100 MHz), 110→5 (120 MHz), 101→6 (133 MHz). The SDRAM code equals the CPU code in these modes.
- R5: PCI code by mode: 001→1 (25), 100 and 110→2 (30), 010, 101 and 111→3 (33.3). AGP code by mode: 001→1 (50), 100 and 110→2 (60), 010, 101 and 111→3 (66.6).
- R6: In modes other than 000 and 011, the USB/IO code is 1 (48 MHz) for a latched USB strap of 0 and 2 (24 MHz) for a latched 1.
- R7: Mode 011 drives `test_mode_o`=1, CPU code 7 (test clock /2), SDRAM code 7 (/6), PCI code 4 (/3) and AGP code 4 (/3). The USB/IO code is 3 (/4) for a latched strap of 0 and 4 (/8) for a latched 1.
- R8: With `reg_sel_i`=1 the mode is `reg_mode_i` (bit 2 test, bit 1 select 1, bit 0 select 0). With `reg_sel_i`=0 the mode is {`test_pin_i`, latched select 1, latched select 0}.
- R9: The third rising edge of `pci_stop_i`, counted while `xtal_lvl_i` stays 0, forces mode 011 from the clock edge that sees it. This overrides both mode sources.
- R10: A cycle with `xtal_lvl_i`=1 discards the edges counted so far. Fewer than three counted edges leave the mode unchanged.
- R11: Once forced, test mode holds until reset, whatever later edges or crystal levels arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| fs_pad_i | input | 2 | Frequency-select straps read from the pads |
| usb_pad_i | input | 1 | USB/IO rate strap read from the pad |
| test_pin_i | input | 1 | Test bit of the pin-derived mode |
| reg_mode_i | input | 3 | Register-supplied mode |
| reg_sel_i | input | 1 | 1 selects the register mode |
| pci_stop_i | input | 1 | PCI stop pin level |
| xtal_lvl_i | input | 1 | Crystal input level |
| cpu_sel_o | output | 3 | CPU divider select code |
| sdram_sel_o | output | 3 | SDRAM divider select code |
| pci_sel_o | output | 3 | PCI divider select code |
| agp_sel_o | output | 3 | AGP divider select code |
| usb_sel_o | output | 3 | USB/IO divider select code |
| hiz_o | output | 1 | All clock outputs to high impedance |
| test_mode_o | output | 1 | Test mode active |
| strap_oe_o | output | 1 | Strap pads switched to output drive |

## Verification
The bench checks the single cycle between reset release and capture. A design that enabled the pad drivers early would fight the strap resistors, and one that captured late would latch its own driven levels. The pads are then changed after capture, to catch a latch that keeps tracking them. All eight register modes are run under both USB strap values, which exposes a swapped rate pair or an off-by-one in the divider codes. The concealed entry path is driven with two pulses, a crystal-high break and then more pulses. A counter that never clears would enter after the break. One that lost saturation would leave test mode on further pulses.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned FS_W   = 2;
  localparam int unsigned MODE_W = FS_W + 1;
  localparam int unsigned CODE_W = 3;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam mode_t MODE_OFF  = 3'b000;
  localparam mode_t MODE_TEST = 3'b011;

  // cpu / sdram codes
  localparam code_t CPU_OFF = 3'd0;
  localparam code_t CPU_50  = 3'd1;
  localparam code_t CPU_66  = 3'd2;
  localparam code_t CPU_90  = 3'd3;
  localparam code_t CPU_100 = 3'd4;
  localparam code_t CPU_120 = 3'd5;
  localparam code_t CPU_133 = 3'd6;
  localparam code_t CPU_TST = 3'd7;

  // pci / agp codes
  localparam code_t BUS_OFF = 3'd0;
  localparam code_t BUS_LO  = 3'd1;
  localparam code_t BUS_MID = 3'd2;
  localparam code_t BUS_HI  = 3'd3;
  localparam code_t BUS_TST = 3'd4;

  // usb/io codes
  localparam code_t USB_OFF = 3'd0;
  localparam code_t USB_48  = 3'd1;
  localparam code_t USB_24  = 3'd2;
  localparam code_t USB_T4  = 3'd3;
  localparam code_t USB_T8  = 3'd4;
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned FS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FS_W-1:0] fs_pad_i,
  input  logic            usb_pad_i,
  output logic [FS_W-1:0] fs_o,
  output logic            usb24_o,
  output logic            done_o
);
  logic [FS_W-1:0] fs_q;
  logic            usb_q;
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q   <= '0;
      usb_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      fs_q   <= fs_pad_i;
      usb_q  <= usb_pad_i;
      done_q <= 1'b1;
    end
  end

  assign fs_o    = fs_q;
  assign usb24_o = usb_q;
  assign done_o  = done_q;

  // R1
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
  // R2
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> ($stable(fs_q) && $stable(usb_q)));
endmodule

// File: rtl/test_entry_det.sv
module test_entry_det #(
  parameter int unsigned EDGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic xtal_i,
  output logic entered_o
);
  localparam int unsigned CW = $clog2(EDGES + 1);

  logic          stop_q;
  logic [CW-1:0] cnt_q;
  logic          entered_q;
  logic          rise;

  assign rise = stop_i & ~stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q    <= 1'b1;  // pin idles high
      cnt_q     <= '0;
      entered_q <= 1'b0;
    end else begin
      stop_q <= stop_i;
      if (!entered_q) begin
        if (xtal_i) begin
          cnt_q <= '0;
        end else if (rise) begin
          if (cnt_q == CW'(EDGES - 1)) begin
            cnt_q     <= CW'(EDGES);  // saturate
            entered_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign entered_o = entered_q;

  // R11
  entered_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entered_q |=> entered_q);
  // R10
  xtal_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!entered_q && xtal_i) |=> (cnt_q == '0 && !entered_q));
  // R9
  entry_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!entered_q && !rise) |=> !entered_q);
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import strap_pkg::*;
(
  input  mode_t mode_i,
  input  logic  usb24_i,
  output code_t cpu_o,
  output code_t sdram_o,
  output code_t pci_o,
  output code_t agp_o,
  output code_t usb_o,
  output logic  hiz_o,
  output logic  test_o
);
  code_t usb_norm;
  assign usb_norm = usb24_i ? USB_24 : USB_48;

  always_comb begin
    cpu_o  = CPU_OFF;
    pci_o  = BUS_OFF;
    agp_o  = BUS_OFF;
    usb_o  = usb_norm;
    hiz_o  = 1'b0;
    test_o = 1'b0;
    unique case (mode_i)
      3'b000: begin hiz_o = 1'b1; usb_o = USB_OFF; end
      3'b001: begin cpu_o = CPU_50;  pci_o = BUS_LO;  agp_o = BUS_LO;  end
      3'b010: begin cpu_o = CPU_66;  pci_o = BUS_HI;  agp_o = BUS_HI;  end
      3'b011: begin
        cpu_o  = CPU_TST;
        pci_o  = BUS_TST;
        agp_o  = BUS_TST;
        usb_o  = usb24_i ? USB_T8 : USB_T4;
        test_o = 1'b1;
      end
      3'b100: begin cpu_o = CPU_90;  pci_o = BUS_MID; agp_o = BUS_MID; end
      3'b101: begin cpu_o = CPU_133; pci_o = BUS_HI;  agp_o = BUS_HI;  end
      3'b110: begin cpu_o = CPU_120; pci_o = BUS_MID; agp_o = BUS_MID; end
      default: begin cpu_o = CPU_100; pci_o = BUS_HI; agp_o = BUS_HI; end
    endcase
  end

  // sdram tracks cpu except in test, where the same code means /6
  assign sdram_o = cpu_o;
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
  import strap_pkg::*;
#(
  parameter int unsigned ENTRY_EDGES = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  fs_pad_i,
  input  logic        usb_pad_i,
  input  logic        test_pin_i,
  input  logic [2:0]  reg_mode_i,
  input  logic        reg_sel_i,
  input  logic        pci_stop_i,
  input  logic        xtal_lvl_i,
  output logic [2:0]  cpu_sel_o,
  output logic [2:0]  sdram_sel_o,
  output logic [2:0]  pci_sel_o,
  output logic [2:0]  agp_sel_o,
  output logic [2:0]  usb_sel_o,
  output logic        hiz_o,
  output logic        test_mode_o,
  output logic        strap_oe_o
);
  logic [FS_W-1:0] fs_l;
  logic            usb24_l;
  logic            cap_done;
  logic            forced;
  mode_t           mode_src;
  mode_t           mode_eff;

  strap_capture #(.FS_W(FS_W)) i_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fs_pad_i (fs_pad_i),
    .usb_pad_i(usb_pad_i),
    .fs_o     (fs_l),
    .usb24_o  (usb24_l),
    .done_o   (cap_done)
  );

  test_entry_det #(.EDGES(ENTRY_EDGES)) i_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stop_i   (pci_stop_i),
    .xtal_i   (xtal_lvl_i),
    .entered_o(forced)
  );

  assign mode_src = reg_sel_i ? mode_t'(reg_mode_i) : {test_pin_i, fs_l};
  assign mode_eff = forced ? MODE_TEST : mode_src;

  mode_decode i_dec (
    .mode_i (mode_eff),
    .usb24_i(usb24_l),
    .cpu_o  (cpu_sel_o),
    .sdram_o(sdram_sel_o),
    .pci_o  (pci_sel_o),
    .agp_o  (agp_sel_o),
    .usb_o  (usb_sel_o),
    .hiz_o  (hiz_o),
    .test_o (test_mode_o)
  );

  assign strap_oe_o = cap_done;

  // R3
  hiz_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_o |-> (cpu_sel_o == 3'd0 && pci_sel_o == 3'd0 && agp_sel_o == 3'd0
               && usb_sel_o == 3'd0 && !test_mode_o));
  // R9
  forced_test_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    forced |-> (test_mode_o && cpu_sel_o == 3'd7 && pci_sel_o == 3'd4));
  // R7
  test_codes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_o |-> (sdram_sel_o == 3'd7 && agp_sel_o == 3'd4 && usb_sel_o[2:1] != 2'b00));
endmodule

// File: tb/test_strap_mode_ctrl.sv
module test_strap_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fs_pad = 2'b00;
  logic       usb_pad = 1'b0;
  logic       test_pin = 1'b1;
  logic [2:0] reg_mode = 3'b000;
  logic       reg_sel = 1'b0;
  logic       pci_stop = 1'b1;
  logic       xtal = 1'b1;
  logic [2:0] cpu, sdram, pci, agp, usb;
  logic       hiz, tmode, oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [17:0] v;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  strap_mode_ctrl i_strap_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fs_pad_i(fs_pad), .usb_pad_i(usb_pad),
    .test_pin_i(test_pin), .reg_mode_i(reg_mode), .reg_sel_i(reg_sel),
    .pci_stop_i(pci_stop), .xtal_lvl_i(xtal),
    .cpu_sel_o(cpu), .sdram_sel_o(sdram), .pci_sel_o(pci), .agp_sel_o(agp),
    .usb_sel_o(usb), .hiz_o(hiz), .test_mode_o(tmode), .strap_oe_o(oe)
  );

  function automatic logic [17:0] model(int m, bit ul, bit en);
    int c, p, a, u, s;
    case (m)
      0: begin c = 0; p = 0; a = 0; end
      1: begin c = 1; p = 1; a = 1; end
      2: begin c = 2; p = 3; a = 3; end
      3: begin c = 7; p = 4; a = 4; end
      4: begin c = 3; p = 2; a = 2; end
      5: begin c = 6; p = 3; a = 3; end
      6: begin c = 5; p = 2; a = 2; end
      default: begin c = 4; p = 3; a = 3; end
    endcase
    s = c;
    if (m == 0) u = 0;
    else if (m == 3) u = ul ? 4 : 3;
    else u = ul ? 2 : 1;
    return {c[2:0], s[2:0], p[2:0], a[2:0], u[2:0], (m == 0), (m == 3), en};
  endfunction

  // monitor: compares one queued item per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      logic [17:0] act;
      e = sb.pop_front();
      act = {cpu, sdram, pci, agp, usb, hiz, tmode, oe};
      checks++;
      if (act !== e.v) begin
        failures++;
        $display("FAIL %s actual=%05h expected=%05h", e.tag, act, e.v);
      end
    end
  end

  task automatic at_drive();
    @(negedge clk);
    #2;
  endtask

  task automatic push(int m, bit ul, bit en, string tag);
    exp_t e;
    e.v = model(m, ul, en);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic pulse_stop();
    at_drive(); pci_stop = 1'b0;
    at_drive(); pci_stop = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // straps 11, usb 1, test pin 1
    fs_pad = 2'b11; usb_pad = 1'b1; test_pin = 1'b1;
    at_drive(); at_drive();
    push(4, 0, 0, "R1 in reset");
    at_drive();
    @(posedge clk); #1 rst_n = 1'b1;
    push(4, 0, 0, "R1 before capture");
    at_drive();
    push(7, 1, 1, "R2 R4 R5 R6 mode 111 captured");
    at_drive(); fs_pad = 2'b00; usb_pad = 1'b0;
    push(7, 1, 1, "R2 pads ignored after capture");
    at_drive(); test_pin = 1'b0;
    push(3, 1, 1, "R7 R8 pin test mode usb /8");
    at_drive(); test_pin = 1'b1; reg_sel = 1'b1;
    for (int m = 0; m < 8; m++) begin
      reg_mode = 3'(m);
      push(m, 1, 1, $sformatf("R3 R4 R5 R7 R8 reg mode %0d usb24", m));
      at_drive();
    end
    reg_sel = 1'b0;

    // second power-on: straps 01, usb 0, test pin 0 -> mode 001
    rst_n = 1'b0; fs_pad = 2'b01; usb_pad = 1'b0; test_pin = 1'b0;
    at_drive(); rst_n = 1'b1;
    push(1, 0, 1, "R2 R6 second capture mode 001");
    at_drive(); fs_pad = 2'b10;
    reg_sel = 1'b1;
    for (int m = 0; m < 8; m++) begin
      reg_mode = 3'(m);
      push(m, 0, 1, $sformatf("R3 R4 R5 R6 R7 reg mode %0d usb48", m));
      at_drive();
    end
    reg_mode = 3'b111;

    // concealed entry
    xtal = 1'b0;
    pulse_stop(); pulse_stop();
    push(7, 0, 1, "R10 two edges only");
    at_drive(); xtal = 1'b1;
    push(7, 0, 1, "R10 crystal high clears");
    at_drive(); xtal = 1'b0;
    pulse_stop(); pulse_stop();
    push(7, 0, 1, "R10 count restarted");
    pulse_stop();
    push(3, 0, 1, "R9 third edge forces test over register");
    at_drive(); reg_sel = 1'b0;
    push(3, 0, 1, "R9 forced over pin source");
    pulse_stop(); xtal = 1'b1;
    push(3, 0, 1, "R11 stays after more edges");
    at_drive(); pci_stop = 1'b0;
    push(3, 0, 1, "R11 stays with crystal high");
    at_drive(); pci_stop = 1'b1;

    // reset leaves test mode; straps now 10, test pin 1 -> mode 110
    rst_n = 1'b0; test_pin = 1'b1; usb_pad = 1'b1;
    at_drive(); rst_n = 1'b1;
    push(6, 1, 1, "R9 R2 reset clears forced test");
    at_drive(); at_drive();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule